// File: doc/BRIEF.md
# Calendar Alarm Match Controller

This block watches a running calendar time and raises an alarm when that time reaches a programmed instant. There are six alarm fields: seconds, minutes, hours, date, month and day-of-week. Each field is one byte. Bit 7 of the byte switches that field into the comparison, and bits 6:0 hold its BCD value. Fields that are switched off are ignored. The alarm fires only when all of the switched-on fields equal the current time.

The comparison is made only on the cycle when the one-cycle time-update tick is high. A matching second or minute therefore gives exactly one event. There are two signalling modes, chosen by `modeRepeat`:

- **One-shot mode:** the sticky status flag is set and the active-low interrupt stays asserted until software clears the flag.
- **Repeating mode:** every match sets the flag and gives a fixed-length low pulse on the interrupt. Nobody needs to service the flag for the next pulse to occur.

Software clears the flag in either of two ways:

- It writes 0 to the flag.
- It reads the status, if auto-clear is enabled.

While the frequency output is enabled, the alarm is inactive.

Top module: `alarm_match_top`

## Requirements
- R1: Each alarm byte uses bit 7 as its enable and bits 6:0 as the BCD value (seconds 30 enabled is 8'hB0). A field with bit 7 at 0 is left out of the comparison, whatever the time value in that field.
- R2: A match is taken only on a cycle with `tick` high, and only when every enabled field equals its time field. `almFlag` shows the result from the cycle after that tick. A full match without `tick` changes nothing.
- R3: No event occurs when no alarm byte has bit 7 set, or when `freqOutEn` is 1.
- R4: With `modeRepeat`=0, `irqN` is low exactly while `almFlag` is 1. It stays low over any number of cycles until the flag is cleared.
- R5: With `modeRepeat`=1, every match sets `almFlag`. It also drives `irqN` low for exactly PULSE_LEN cycles (default 16), starting the cycle after the tick. `irqN` then returns high while `almFlag` remains set, and a later match pulses again without the flag being cleared.
- R6: A cycle with `statWr`=1 and `statWrData`=0 clears `almFlag` in the next cycle. With `statWrData`=1, the write leaves the flag unchanged.
- R7: A cycle with `statRd`=1 clears `almFlag` when `autoClrEn`=1. When `autoClrEn`=0, the read has no effect.
- R8: A match in the same cycle as a clearing write or a clearing read leaves `almFlag` set.
- R9: In repeating mode, a new match while a pulse is running restarts the full PULSE_LEN low period from that match.
- R10: After reset, `almFlag` is 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe on each time update |
| timeSec | input | 7 | Current seconds, BCD |
| timeMin | input | 7 | Current minutes, BCD |
| timeHour | input | 7 | Current hours, BCD |
| timeDate | input | 7 | Current date, BCD |
| timeMonth | input | 7 | Current month, BCD |
| timeDow | input | 7 | Current day of week |
| almSec | input | 8 | Seconds alarm: bit 7 enable, 6:0 BCD |
| almMin | input | 8 | Minutes alarm |
| almHour | input | 8 | Hours alarm |
| almDate | input | 8 | Date alarm |
| almMonth | input | 8 | Month alarm |
| almDow | input | 8 | Day-of-week alarm |
| modeRepeat | input | 1 | 0 one-shot level, 1 repeating pulse |
| autoClrEn | input | 1 | Status read clears the flag |
| freqOutEn | input | 1 | Frequency output on; alarm inactive |
| statRd | input | 1 | Status read strobe |
| statWr | input | 1 | Status write strobe |
| statWrData | input | 1 | Value written to the alarm flag |
| irqN | output | 1 | Active-low interrupt |
| almFlag | output | 1 | Sticky alarm status flag |

## Verification
The hardest case to reach from the ports is a match that falls in the same cycle as a clearing write or a clearing read. The stimulus raises `tick` on a matching time and holds the clear strobe in that same cycle. It then checks that the flag survives. A second hard case is a new match that lands inside a running repeat pulse. The bench fires a second tick five cycles into a pulse, then samples `irqN` at the last low cycle and at the first high cycle counted from the second tick.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic loadPulse;
  } almStrobeT;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W:0]   almReg,
  input  logic [VAL_W-1:0] nowVal,
  output logic             fieldEn,
  output logic             fieldOk
);
  // Bit VAL_W is the enable; a disabled field always agrees.
  assign fieldEn = almReg[VAL_W];
  assign fieldOk = !almReg[VAL_W] || (almReg[VAL_W-1:0] == nowVal);
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int VAL_W      = 7,
  parameter int PULSE_LEN  = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               tick,
  input  logic                               freqOutEn,
  input  logic [NUM_FIELDS-1:0][VAL_W:0]     almVec,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0]   timeVec,
  input  almStrobeT                          strobe,
  output logic                               hitNow,
  output logic                               flagQ,
  output logic                               pulseActive
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] PULSE_INIT = CNT_W'(PULSE_LEN);

  logic [NUM_FIELDS-1:0] enVec;
  logic [NUM_FIELDS-1:0] okVec;
  logic                  armed;
  logic [CNT_W-1:0]      pulseCnt;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    alarm_field_cmp #(.VAL_W(VAL_W)) u_cmp (
      .almReg (almVec[f]),
      .nowVal (timeVec[f]),
      .fieldEn(enVec[f]),
      .fieldOk(okVec[f])
    );
  end

  assign armed  = (|enVec) && !freqOutEn;
  assign hitNow = tick && armed && (&okVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.setFlag) begin
      flagQ <= 1'b1;
    end else if (strobe.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.loadPulse) begin
      pulseCnt <= PULSE_INIT;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign pulseActive = (pulseCnt != '0);
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic      hitNow,
  input  logic      modeRepeat,
  input  logic      autoClrEn,
  input  logic      statRd,
  input  logic      statWr,
  input  logic      statWrData,
  input  logic      flagQ,
  input  logic      pulseActive,
  output almStrobeT strobe,
  output logic      irqLow
);
  logic clrReq;

  always_comb begin
    clrReq           = (statWr && !statWrData) || (statRd && autoClrEn);
    strobe.setFlag   = hitNow;
    // A set in the same cycle wins over any clear.
    strobe.clrFlag   = clrReq && !hitNow;
    strobe.loadPulse = hitNow && modeRepeat;
    irqLow           = modeRepeat ? pulseActive : flagQ;
  end
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [6:0] timeSec,
  input  logic [6:0] timeMin,
  input  logic [6:0] timeHour,
  input  logic [6:0] timeDate,
  input  logic [6:0] timeMonth,
  input  logic [6:0] timeDow,
  input  logic [7:0] almSec,
  input  logic [7:0] almMin,
  input  logic [7:0] almHour,
  input  logic [7:0] almDate,
  input  logic [7:0] almMonth,
  input  logic [7:0] almDow,
  input  logic       modeRepeat,
  input  logic       autoClrEn,
  input  logic       freqOutEn,
  input  logic       statRd,
  input  logic       statWr,
  input  logic       statWrData,
  output logic       irqN,
  output logic       almFlag
);
  localparam int NUM_FIELDS = 6;
  localparam int VAL_W      = 7;

  logic [NUM_FIELDS-1:0][VAL_W:0]   almVec;
  logic [NUM_FIELDS-1:0][VAL_W-1:0] timeVec;
  almStrobeT strobe;
  logic hitNow;
  logic flagQ;
  logic pulseActive;
  logic irqLow;

  assign almVec  = {almDow, almMonth, almDate, almHour, almMin, almSec};
  assign timeVec = {timeDow, timeMonth, timeDate, timeHour, timeMin, timeSec};

  alarm_datapath #(
    .NUM_FIELDS(NUM_FIELDS),
    .VAL_W     (VAL_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .freqOutEn  (freqOutEn),
    .almVec     (almVec),
    .timeVec    (timeVec),
    .strobe     (strobe),
    .hitNow     (hitNow),
    .flagQ      (flagQ),
    .pulseActive(pulseActive)
  );

  alarm_ctrl u_ctrl (
    .hitNow     (hitNow),
    .modeRepeat (modeRepeat),
    .autoClrEn  (autoClrEn),
    .statRd     (statRd),
    .statWr     (statWr),
    .statWrData (statWrData),
    .flagQ      (flagQ),
    .pulseActive(pulseActive),
    .strobe     (strobe),
    .irqLow     (irqLow)
  );

  assign irqN    = !irqLow;
  assign almFlag = flagQ;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [5:0] almEnVec,
  input logic       modeRepeat,
  input logic       autoClrEn,
  input logic       freqOutEn,
  input logic       statRd,
  input logic       statWr,
  input logic       statWrData,
  input logic       hitNow,
  input logic       irqN,
  input logic       almFlag
);
  localparam int CW = $clog2(PULSE_LEN + 2);
  localparam logic [CW-1:0] SAT = CW'(PULSE_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(PULSE_LEN);

  logic [CW-1:0] sinceTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceTick <= SAT;
    else if (tick)           sinceTick <= CW'(1);
    else if (sinceTick != SAT) sinceTick <= sinceTick + 1'b1;
  end

  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !almFlag) |=> !almFlag); // R2
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((almEnVec == '0 || freqOutEn) && !almFlag) |=> !almFlag); // R3
  AST_ONESHOT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !modeRepeat |-> (irqN == !almFlag)); // R4
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (modeRepeat && !irqN) |-> (sinceTick <= LIM)); // R5
  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !statWrData && !tick) |=> !almFlag); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && autoClrEn && !tick) |=> !almFlag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> almFlag); // R8
endmodule

bind alarm_match_top alarm_match_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .almEnVec  ({almDow[7], almMonth[7], almDate[7], almHour[7], almMin[7], almSec[7]}),
  .modeRepeat(modeRepeat),
  .autoClrEn (autoClrEn),
  .freqOutEn (freqOutEn),
  .statRd    (statRd),
  .statWr    (statWr),
  .statWrData(statWrData),
  .hitNow    (hitNow),
  .irqN      (irqN),
  .almFlag   (almFlag)
);

// File: tb/alarm_match_top_test.sv
module alarm_match_top_test;
  localparam int PL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [6:0] timeSec = '0, timeMin = '0, timeHour = '0;
  logic [6:0] timeDate = '0, timeMonth = '0, timeDow = '0;
  logic [7:0] almSec = '0, almMin = '0, almHour = '0;
  logic [7:0] almDate = '0, almMonth = '0, almDow = '0;
  logic modeRepeat = 1'b0, autoClrEn = 1'b0, freqOutEn = 1'b0;
  logic statRd = 1'b0, statWr = 1'b0, statWrData = 1'b0;
  logic irqN, almFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    tgt;
    bit    flag;
    bit    irq;
    string tag;
  } expT;
  expT sb[$];

  alarm_match_top #(.PULSE_LEN(PL)) uut (.*);

  always #10 clk = !clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every queued expectation whose cycle has come.
  always @(negedge clk) begin
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].tgt == cyc) begin
        checks++;
        if (almFlag !== sb[i].flag || irqN !== sb[i].irq) begin
          errors++;
          $display("FAIL %s cyc %0d: flag=%0b irqN=%0b expected flag=%0b irqN=%0b",
                   sb[i].tag, cyc, almFlag, irqN, sb[i].flag, sb[i].irq);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expectIn(int k, bit f, bit irq, string tag);
    expT e;
    e.tgt = cyc + k; e.flag = f; e.irq = irq; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickOnce();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic wrFlag(bit v);
    statWr = 1'b1; statWrData = v; @(negedge clk); statWr = 1'b0; statWrData = 1'b0;
  endtask

  task automatic setDay();
    almSec = 8'h00; almMin = 8'hB0; almHour = 8'h91;
    almDate = 8'h81; almMonth = 8'h81; almDow = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    expectIn(0, 0, 1, "R10 reset");
    step(1);

    // One-shot day alarm: 11:30 on 01/01, seconds and weekday ignored.
    setDay();
    timeDate = 7'h01; timeMonth = 7'h01; timeDow = 7'h03;
    timeHour = 7'h11; timeMin = 7'h29; timeSec = 7'h59;
    tickOnce(); expectIn(0, 0, 1, "R2 mismatch");
    timeMin = 7'h30; timeSec = 7'h00;
    step(1); expectIn(0, 0, 1, "R2 no tick");
    step(1);
    tickOnce(); expectIn(0, 1, 0, "R1 R4 match set");
    step(5); expectIn(0, 1, 0, "R4 level held");
    step(1);
    wrFlag(1'b1); expectIn(0, 1, 0, "R6 write one ignored");
    step(1);
    wrFlag(1'b0); expectIn(0, 0, 1, "R6 write zero clears");
    step(1);
    timeDow = 7'h06; timeSec = 7'h17;
    tickOnce(); expectIn(0, 1, 0, "R1 disabled fields ignored");
    step(1); wrFlag(1'b0); step(1);

    // Disarmed cases.
    freqOutEn = 1'b1;
    tickOnce(); expectIn(0, 0, 1, "R3 freq output on");
    freqOutEn = 1'b0; step(1);
    almMin = 8'h00; almHour = 8'h00; almDate = 8'h00; almMonth = 8'h00;
    tickOnce(); expectIn(0, 0, 1, "R3 nothing enabled");
    setDay(); step(1);

    // Read clearing.
    tickOnce(); step(1);
    autoClrEn = 1'b0; statRd = 1'b1; step(1); statRd = 1'b0;
    expectIn(0, 1, 0, "R7 read without auto-clear");
    step(1);
    autoClrEn = 1'b1; statRd = 1'b1; step(1); statRd = 1'b0;
    expectIn(0, 0, 1, "R7 read with auto-clear");
    step(1);

    // Set wins over clears in the same cycle.
    statWr = 1'b1; statWrData = 1'b0;
    tickOnce(); statWr = 1'b0;
    expectIn(0, 1, 0, "R8 match beats write clear");
    step(1);
    statRd = 1'b1;
    tickOnce(); statRd = 1'b0;
    expectIn(0, 1, 0, "R8 match beats read clear");
    step(1); wrFlag(1'b0); autoClrEn = 1'b0; step(1);

    // Repeating mode, seconds-only alarm at 30.
    modeRepeat = 1'b1;
    almSec = 8'hB0; almMin = 8'h00; almHour = 8'h00;
    almDate = 8'h00; almMonth = 8'h00; almDow = 8'h00;
    timeSec = 7'h29;
    tickOnce(); expectIn(0, 0, 1, "R5 seconds mismatch");
    timeSec = 7'h30;
    tickOnce();
    expectIn(0, 1, 0, "R1 R5 pulse start");
    expectIn(PL - 1, 1, 0, "R5 pulse last low");
    expectIn(PL, 1, 1, "R5 pulse end flag kept");
    step(PL + 4);
    tickOnce();
    expectIn(0, 1, 0, "R5 repeat without clear");
    expectIn(PL, 1, 1, "R5 repeat end");
    step(PL + 4);

    // Restart during a running pulse.
    tickOnce(); step(4);
    tickOnce();
    expectIn(PL - 1, 1, 0, "R9 restarted low");
    expectIn(PL, 1, 1, "R9 restarted end");
    step(PL + 6);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule